// File: doc/BRIEF.md
# Nonvolatile Shadow Store and Recall Controller

This block sits beside a small SRAM array and keeps a nonvolatile shadow copy of it. All traffic reaches the block as single-cycle access events. Each event is a read or a write that the chip enable controls. A read only returns data when output enable is high. Two events move data between the arrays. A store copies the SRAM into the shadow cells. A recall copies the shadow cells back into the SRAM.

Software starts a store by reading six fixed addresses in order, with no other access between them. The store then runs an erase phase and a program phase. A recall is requested when the supply-low indication is seen, and the request is held until the supply-good indication is present. The recall then starts by itself. Both operations last a parameterised number of clock cycles. While either one runs, `busy` is high and the SRAM port ignores every access.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: When idle, an accepted write stores `acc_wdata` at the SRAM entry selected by the low address bits. An accepted read with `acc_oe` high gives that entry's data on `rd_data`, with `rd_valid` high, in the cycle after the access. A read with `acc_oe` low gives no `rd_valid`.
- R2: Six accepted reads of addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0, in that order, start a store. `nv_mode` reads 1 (erase) in the cycle after the sixth read. The level of `acc_oe` does not matter for the sequence.
- R3: An accepted write in the middle of the sequence resets its progress, including a write to the first sequence address. The remaining reads then start no store.
- R4: A read of any address other than the expected one, in the middle of the sequence, resets its progress. No store or recall follows.
- R5: A mismatching read whose address equals the first sequence address counts as step one of a new sequence.
- R6: A store holds `nv_mode`=1 (erase) for ERASE_CYC cycles, then `nv_mode`=2 (program) for PROG_CYC cycles, then returns to `nv_mode`=0 (idle).
- R7: When the program phase ends, the shadow cells hold a copy of the SRAM contents as they were when the store started. A later recall restores exactly that copy.
- R8: While `busy` is high (`nv_mode` not 0), accesses have no effect. Writes do not change the SRAM, reads give no `rd_valid`, and no access advances the sequence.
- R9: A cycle with `pwr_low` high latches a recall request. The recall starts, giving `nv_mode`=3, in the cycle after the first clock edge where the request is pending, `pwr_good` is high, `pwr_low` is low and the block is idle. After RESTORE_CYC cycles the SRAM holds the shadow contents and the block is idle.
- R10: A recall that starts on the same edge as a completed sequence wins, and no store results. The sequence progress is cleared, so one more final address afterwards does nothing.
- R11: After reset, `nv_mode` is 0, `busy` and `rd_valid` are 0, `rd_data` is 0 and no recall request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access event, controlled by chip enable, this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_oe | input | 1 | Output enable, gates read data |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data |
| rd_valid | output | 1 | Read data valid |
| pwr_low | input | 1 | Supply below reset level |
| pwr_good | input | 1 | Supply above switch level |
| busy | output | 1 | Store or recall in progress |
| nv_mode | output | 2 | 0 idle, 1 erase, 2 program, 3 recall |

## Verification
The bench targets four corner cases of the sequence detector: an aborting write to the first sequence address, a stray read, a repeat of the first address that restarts the sequence, and a sequence read with output enable low. A detector that mishandled one of these would start a store it should not start, or miss one it should start. Phase lengths are measured cycle by cycle, so an off-by-one counter shows up as a wrong duration. Writes made during a store must not reach the copy that a later recall returns. The bench also completes a sequence on the same edge as a pending recall starts, to catch a wrong priority and progress that was never cleared.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    NVM_IDLE   = 2'd0,
    NVM_ERASE  = 2'd1,
    NVM_PROG   = 2'd2,
    NVM_RECALL = 2'd3
  } nv_mode_e;

  localparam int UNLOCK_LEN = 6;

  // Unlock addresses in the order they must be read.
  function automatic logic [14:0] unlock_addr(input logic [2:0] step);
    case (step)
      3'd0:    unlock_addr = 15'h0E38;
      3'd1:    unlock_addr = 15'h31C7;
      3'd2:    unlock_addr = 15'h03E0;
      3'd3:    unlock_addr = 15'h3C1F;
      3'd4:    unlock_addr = 15'h303F;
      default: unlock_addr = 15'h0FC0;
    endcase
  endfunction
endpackage

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_write,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              clear,
  output logic              fire
);
  localparam int STEP_W = $clog2(UNLOCK_LEN);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(UNLOCK_LEN - 1);

  logic [STEP_W-1:0] step_q, step_d;
  logic              hit, hit_first;

  always_comb begin
    hit       = (ev_addr == ADDR_W'(unlock_addr(3'(step_q))));
    hit_first = (ev_addr == ADDR_W'(unlock_addr(3'd0)));
    fire      = ev_valid && !ev_write && hit && (step_q == LAST);
    step_d    = step_q;
    if (clear) begin
      step_d = '0;
    end else if (ev_valid) begin
      if (ev_write)       step_d = '0;
      else if (hit)       step_d = (step_q == LAST) ? '0 : step_q + 1'b1;
      else if (hit_first) step_d = STEP_W'(1);
      else                step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end
endmodule

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    zero = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nvs_storage.sv
module nvs_storage #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              nv_erase,
  input  logic              nv_program,
  input  logic              sram_restore
);
  logic [DATA_W-1:0] sram_q [DEPTH];
  logic [DATA_W-1:0] nv_q   [DEPTH];

  always_ff @(posedge clk) begin
    if (sram_restore)  sram_q <= nv_q;
    else if (wr_en)    sram_q[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (nv_erase) begin
      for (int i = 0; i < DEPTH; i++) nv_q[i] <= '1;
    end else if (nv_program) begin
      nv_q <= sram_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sram_q[idx];
  end
endmodule

// File: rtl/nv_shadow_ctrl.sv
module nv_shadow_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int ERASE_CYC   = 40,
  parameter int PROG_CYC    = 60,
  parameter int RESTORE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_oe,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              pwr_low,
  input  logic              pwr_good,
  output logic              busy,
  output logic [1:0]        nv_mode
);
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ?
                           ((ERASE_CYC > RESTORE_CYC) ? ERASE_CYC : RESTORE_CYC) :
                           ((PROG_CYC > RESTORE_CYC) ? PROG_CYC : RESTORE_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  nv_mode_e          mode_q, mode_d;
  logic              pend_q, pend_d;
  logic              rdv_q, rdv_d;
  logic              ev_valid, seq_fire, start_recall, start_store;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              do_erase, do_prog, do_restore;
  logic              wr_en, rd_en;

  assign busy     = (mode_q != NVM_IDLE);
  assign ev_valid = acc_valid && !busy;
  assign wr_en    = ev_valid && acc_write;
  assign rd_en    = ev_valid && !acc_write && acc_oe;

  assign start_recall = pend_q && pwr_good && !pwr_low && (mode_q == NVM_IDLE);
  assign start_store  = seq_fire && (mode_q == NVM_IDLE) && !start_recall;

  always_comb begin
    mode_d     = mode_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    do_erase   = 1'b0;
    do_prog    = 1'b0;
    do_restore = 1'b0;
    case (mode_q)
      NVM_IDLE: begin
        if (start_recall) begin
          mode_d   = NVM_RECALL;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RESTORE_CYC - 1);
        end else if (start_store) begin
          mode_d   = NVM_ERASE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(ERASE_CYC - 1);
          do_erase = 1'b1;
        end
      end
      NVM_ERASE: if (tmr_zero) begin
        mode_d   = NVM_PROG;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PROG_CYC - 1);
      end
      NVM_PROG: if (tmr_zero) begin
        mode_d  = NVM_IDLE;
        do_prog = 1'b1;
      end
      default: if (tmr_zero) begin
        mode_d     = NVM_IDLE;
        do_restore = 1'b1;
      end
    endcase
    if (pwr_low)           pend_d = 1'b1;
    else if (start_recall) pend_d = 1'b0;
    else                   pend_d = pend_q;
    rdv_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= NVM_IDLE;
      pend_q <= 1'b0;
      rdv_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
      rdv_q  <= rdv_d;
    end
  end

  assign rd_valid = rdv_q;
  assign nv_mode  = mode_q;

  nvs_seq_detect #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_write(acc_write),
    .ev_addr(acc_addr), .clear(start_recall), .fire(seq_fire)
  );

  nvs_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  nvs_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .idx(acc_addr[IDX_W-1:0]), .wdata(acc_wdata), .rdata(rd_data),
    .nv_erase(do_erase), .nv_program(do_prog), .sram_restore(do_restore)
  );
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
  parameter int ERASE_CYC = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rd_valid,
  input logic       pwr_good,
  input logic [1:0] nv_mode
);
  int unsigned ecnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ecnt_q <= 0;
    else if (nv_mode == 2'd1) ecnt_q <= ecnt_q + 1;
    else                     ecnt_q <= 0;
  end

  AST_ERASE_THEN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_mode == 2'd1) |=> (nv_mode == 2'd1 || nv_mode == 2'd2)); // R6
  AST_PROG_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_mode == 2'd2) |=> (nv_mode == 2'd2 || nv_mode == 2'd0)); // R6
  AST_NO_ERASE_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_mode == 2'd2 || nv_mode == 2'd3) |=> (nv_mode != 2'd1)); // R6
  AST_ERASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_mode == 2'd1) |-> (ecnt_q < ERASE_CYC)); // R6
  AST_RECALL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_mode == 2'd3) |=> (nv_mode == 2'd3 || nv_mode == 2'd0)); // R9
  AST_RECALL_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_mode == 2'd0 && !pwr_good) |=> (nv_mode != 2'd3)); // R9
  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_valid); // R8
endmodule

bind nv_shadow_ctrl nvs_checker #(.ERASE_CYC(ERASE_CYC)) u_nvs_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid),
  .pwr_good(pwr_good), .nv_mode(nv_mode)
);

// File: tb/tb_nv_shadow_ctrl.sv
module tb_nv_shadow_ctrl;
  localparam int ER = 4, PR = 6, RS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_oe = 1'b0;
  logic [14:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid, busy;
  logic        pwr_low = 1'b0, pwr_good = 1'b1;
  logic [1:0]  nv_mode;

  always #10 clk = ~clk;

  nv_shadow_ctrl #(.ERASE_CYC(ER), .PROG_CYC(PR), .RESTORE_CYC(RS)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_oe(acc_oe), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .pwr_low(pwr_low),
    .pwr_good(pwr_good), .busy(busy), .nv_mode(nv_mode)
  );

  localparam logic [14:0] MAG [6] = '{15'h0E38, 15'h31C7, 15'h03E0,
                                      15'h3C1F, 15'h303F, 15'h0FC0};

  int nchk = 0, nfail = 0;
  logic [7:0] mdl [16];
  logic [7:0] nvmdl [16];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every read result is popped and compared.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1/R8 unexpected rd_valid", int'(rd_data), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data == e, t, int'(rd_data), int'(e));
      end
    end
  end

  // Driver: one access per cycle; live=1 when the block is expected idle.
  task automatic acc(input bit wr, input logic [14:0] a, input logic [7:0] d,
                     input bit oe, input bit live, input string tag);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d; acc_oe = oe;
    if (live && !wr && oe) begin
      exp_q.push_back(mdl[a[3:0]]);
      tag_q.push_back(tag);
    end
    if (live && wr) mdl[a[3:0]] = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic phase_len(input logic [1:0] m, input int len, input string tag);
    int n = 0;
    while (nv_mode == m && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == len, tag, n, len);
  endtask

  task automatic idle_check(input string tag);
    repeat (3) @(negedge clk);
    chk(nv_mode == 2'd0, tag, int'(nv_mode), 0);
  endtask

  task automatic do_recall(input string tag);
    pwr_good = 1'b0; pwr_low = 1'b1;
    @(negedge clk);
    pwr_low = 1'b0;
    repeat (3) @(negedge clk);
    chk(nv_mode == 2'd0, "R9 pending waits for good", int'(nv_mode), 0);
    pwr_good = 1'b1;
    @(negedge clk);
    chk(nv_mode == 2'd3, tag, int'(nv_mode), 3);
    phase_len(2'd3, RS, "R9 restore length");
    for (int i = 0; i < 16; i++) mdl[i] = nvmdl[i];
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(nv_mode == 2'd0, "R11 mode", int'(nv_mode), 0);
    chk(busy == 1'b0, "R11 busy", int'(busy), 0);
    chk(rd_valid == 1'b0, "R11 rd_valid", int'(rd_valid), 0);
    chk(rd_data == 8'h00, "R11 rd_data", int'(rd_data), 0);
    idle_check("R11 no pending recall");

    // R1 plain writes and reads
    for (int i = 0; i < 16; i++) acc(1'b1, 15'(i), 8'(8'h30 + i * 7), 1'b0, 1'b1, "R1");
    for (int i = 0; i < 16; i += 3) acc(1'b0, 15'(i), 8'h0, 1'b1, 1'b1, "R1 readback");
    acc(1'b0, 15'd2, 8'h0, 1'b0, 1'b1, "R1 oe low");
    @(negedge clk);

    // R4 stray read aborts
    for (int i = 0; i < 3; i++) acc(1'b0, MAG[i], 8'h0, 1'b1, 1'b1, "R4 rd");
    acc(1'b0, 15'h0001, 8'h0, 1'b1, 1'b1, "R4 stray");
    for (int i = 3; i < 6; i++) acc(1'b0, MAG[i], 8'h0, 1'b1, 1'b1, "R4 rd");
    idle_check("R4 no store after stray read");

    // R3 write to first address aborts
    for (int i = 0; i < 2; i++) acc(1'b0, MAG[i], 8'h0, 1'b1, 1'b1, "R3 rd");
    acc(1'b1, MAG[0], 8'hC3, 1'b0, 1'b1, "R3 wr");
    for (int i = 2; i < 6; i++) acc(1'b0, MAG[i], 8'h0, 1'b1, 1'b1, "R3 rd");
    idle_check("R3 no store after write");

    // R5 restart on first address, R2 sequence with oe low
    acc(1'b0, MAG[0], 8'h0, 1'b0, 1'b1, "R5");
    acc(1'b0, MAG[1], 8'h0, 1'b0, 1'b1, "R5");
    acc(1'b0, MAG[0], 8'h0, 1'b0, 1'b1, "R5");
    for (int i = 1; i < 6; i++) acc(1'b0, MAG[i], 8'h0, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 16; i++) nvmdl[i] = mdl[i];
    chk(nv_mode == 2'd1, "R2 R5 store started", int'(nv_mode), 1);
    chk(busy == 1'b1, "R8 busy during erase", int'(busy), 1);
    // R8 accesses while busy are ignored
    acc(1'b1, 15'd3, 8'h5A, 1'b0, 1'b0, "R8 wr");
    acc(1'b0, 15'd3, 8'h0, 1'b1, 1'b0, "R8 rd");
    phase_len(2'd1, ER - 2, "R6 erase length");
    phase_len(2'd2, PR, "R6 program length");
    chk(nv_mode == 2'd0 && busy == 1'b0, "R6 idle after store", int'(nv_mode), 0);
    acc(1'b0, 15'd3, 8'h0, 1'b1, 1'b1, "R8 busy write dropped");

    // R7 overwrite SRAM then recall the stored copy
    for (int i = 0; i < 16; i++) acc(1'b1, 15'(i), 8'(8'hA0 ^ i), 1'b0, 1'b1, "R7");
    do_recall("R9 recall starts");
    for (int i = 0; i < 16; i++) acc(1'b0, 15'(i), 8'h0, 1'b1, 1'b1, "R7 restored");

    // R10 recall beats completed sequence
    pwr_good = 1'b0; pwr_low = 1'b1;
    @(negedge clk);
    pwr_low = 1'b0;
    for (int i = 0; i < 5; i++) acc(1'b0, MAG[i], 8'h0, 1'b1, 1'b1, "R10 rd");
    pwr_good = 1'b1;
    acc(1'b0, MAG[5], 8'h0, 1'b1, 1'b1, "R10 rd");
    chk(nv_mode == 2'd3, "R10 recall wins", int'(nv_mode), 3);
    phase_len(2'd3, RS, "R10 restore length");
    for (int i = 0; i < 16; i++) mdl[i] = nvmdl[i];
    acc(1'b0, MAG[5], 8'h0, 1'b1, 1'b1, "R10 rd");
    idle_check("R10 sequence cleared");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all reads returned", exp_q.size(), 0);
    finish_run();
  end
endmodule